// File: doc/BRIEF.md
# Per-Cycle Audio Block Count Sequencer

This block tells an isochronous audio transmitter how many audio data blocks to place in the packet for each bus cycle. The bus runs at 8000 cycles per second. Over time, the number of blocks sent must match the sample rate exactly. For rates that are whole multiples of 8000, every cycle carries the same count. For the 44.1 kHz family, the block steps through a fixed phase pattern. The pattern puts the cycles that carry one extra block as early in each period as it can, which keeps the receiver's buffer from running dry.

A start pulse captures the rate code and the packing mode, and resets the internal phase. After that, each advance strobe asks for the count of one cycle. In blocking mode every packet carries the full interval of the rate, or carries nothing when that cycle has no usable timestamp. In non-blocking mode the rate alone sets the count, following the constant or phased sequences. The count for each advance appears on a registered output one clock later, with a one-cycle valid pulse.

Top module: `cycle_block_pacer`

## Requirements
- R1: After reset, `blk_cnt_o` is 0 and `cnt_vld_o` is 0. An advance strobe given before any start pulse produces no valid pulse.
- R2: The rate code and the mode are captured only on `start_i`. Changes on `fs_code_i` or `blocking_i` while the stream runs have no effect on the counts until the next start.
- R3: An advance accepted while running produces `cnt_vld_o` high for exactly the next clock, with the count on `blk_cnt_o`. If an advance arrives in the same cycle as a start, it is dropped and produces no valid pulse.
- R4: In blocking mode (`blocking_i`=1) with `ts_ok_i`=1, the count is 8 for codes 0 (32k), 1 (44.1k) and 2 (48k). It is 16 for codes 3 (88.2k) and 4 (96k), and 32 for codes 5 (176.4k) and 6 (192k).
- R5: In blocking mode, an advance with `ts_ok_i`=0 (the cycle's timestamp carries the no-info value) gives a count of 0.
- R6: In non-blocking mode, the even codes give a constant count whatever the value of `ts_ok_i`: code 0 gives 4, code 2 gives 6, code 4 gives 12 and code 6 gives 24.
- R7: In non-blocking mode at code 1, the count at phase p is 5 + ((p mod 2) XOR (p==0 OR p>=40)). The first counts after a start are therefore 6,6,5,6,5.
- R8: In non-blocking mode, code 3 gives 12 at phase 0 and 11 at every other phase. Code 5 gives 23 at phase 0 and 22 at every other phase.
- R9: The phase advances once per accepted advance. It wraps to 0 after 80 cycles for code 1, 40 for code 3 and 20 for code 5. Each full period totals 441 blocks.
- R10: A start pulse given while a stream runs returns the phase to 0, so the next count is the phase-0 value.
- R11: Code 7 is not a valid rate and gives a count of 0 in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts or restarts the stream and captures the configuration |
| fs_code_i | input | 3 | Sample-rate code, 0..6 (7 is invalid) |
| blocking_i | input | 1 | 1 selects blocking packing, 0 selects non-blocking |
| adv_i | input | 1 | Advance strobe, one per bus cycle |
| ts_ok_i | input | 1 | 1 when this cycle's timestamp is valid (not the no-info value) |
| blk_cnt_o | output | 6 | Block count for the advanced cycle, registered |
| cnt_vld_o | output | 1 | One-clock pulse marking a fresh count |

## Verification
The assertions assume that `ts_ok_i` is meaningful only in a cycle where `adv_i` is high. They also assume that configuration inputs are read only on a start pulse, so the bench changes `fs_code_i` and `blocking_i` mid-stream on purpose to show they are held. The phase-range and restart checks assume that advances come only while the stream runs. The stimulus therefore gives every advance its own clock, apart from one deliberate collision with a start pulse, and walks each phased rate through a full period plus one wrap.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  localparam int unsigned FS_W = 3;

  typedef enum logic [FS_W-1:0] {
    FS_32K   = 3'd0,
    FS_44K1  = 3'd1,
    FS_48K   = 3'd2,
    FS_88K2  = 3'd3,
    FS_96K   = 3'd4,
    FS_176K4 = 3'd5,
    FS_192K  = 3'd6,
    FS_BAD   = 3'd7
  } fs_code_e;

  typedef struct packed {
    fs_code_e code;
    logic     blocking;
  } pace_cfg_t;

  // true for the fractional (44.1 kHz based) rates
  function automatic logic is_frac_rate(fs_code_e c);
    return c[0] && (c != FS_BAD);
  endfunction
endpackage

// File: rtl/pacer_cfg.sv
module pacer_cfg
  import pacer_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [FS_W-1:0]       code_i,
  input  logic                  blocking_i,
  output logic                  run_o,
  output pace_cfg_t             cfg_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      run_o <= 1'b0;
      cfg_o <= '0;
    end else if (start_i) begin
      run_o          <= 1'b1;
      cfg_o.code     <= fs_code_e'(code_i);
      cfg_o.blocking <= blocking_i;
    end
  end

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_o && !start_i) |=> $stable(cfg_o));
endmodule

// File: rtl/pacer_phase.sv
module pacer_phase
  import pacer_pkg::*;
#(
  parameter int unsigned PH_W        = 7,
  parameter int unsigned BASE_PERIOD = 80
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart_i,
  input  logic            step_i,
  input  pace_cfg_t       cfg_i,
  output logic [PH_W-1:0] phase_o
);
  localparam logic [PH_W-1:0] BASE_L = PH_W'(BASE_PERIOD);

  logic [PH_W-1:0] lim;
  logic            do_step;

  // period halves for each doubling of the rate
  assign lim     = BASE_L >> cfg_i.code[2:1];
  assign do_step = step_i && is_frac_rate(cfg_i.code) && !cfg_i.blocking;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      phase_o <= '0;
    end else if (do_step) begin
      if (phase_o == lim - 1'b1) phase_o <= '0;
      else                       phase_o <= phase_o + 1'b1;
    end
  end

  // R9
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    !restart_i |=> (phase_o < (BASE_L >> cfg_i.code[2:1])));
  // R10
  phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (phase_o == '0));
endmodule

// File: rtl/pacer_count.sv
module pacer_count
  import pacer_pkg::*;
#(
  parameter int unsigned PH_W  = 7,
  parameter int unsigned CNT_W = 6,
  parameter int unsigned HALF  = 40
) (
  input  pace_cfg_t        cfg_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic             ts_ok_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic ph0, late, extra44;

  assign ph0     = (phase_i == '0);
  assign late    = (phase_i >= PH_W'(HALF));
  assign extra44 = phase_i[0] ^ (ph0 || late);

  always_comb begin
    cnt_o = '0;
    if (cfg_i.blocking) begin
      if (ts_ok_i) begin
        unique case (cfg_i.code)
          FS_32K, FS_44K1, FS_48K: cnt_o = CNT_W'(8);
          FS_88K2, FS_96K:         cnt_o = CNT_W'(16);
          FS_176K4, FS_192K:       cnt_o = CNT_W'(32);
          default:                 cnt_o = '0;
        endcase
      end
    end else begin
      unique case (cfg_i.code)
        FS_32K:   cnt_o = CNT_W'(4);
        FS_48K:   cnt_o = CNT_W'(6);
        FS_96K:   cnt_o = CNT_W'(12);
        FS_192K:  cnt_o = CNT_W'(24);
        FS_44K1:  cnt_o = CNT_W'(5) + CNT_W'(extra44);
        FS_88K2:  cnt_o = CNT_W'(11) + CNT_W'(ph0);
        FS_176K4: cnt_o = CNT_W'(22) + CNT_W'(ph0);
        default:  cnt_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/cycle_block_pacer.sv
module cycle_block_pacer
  import pacer_pkg::*;
#(
  parameter int unsigned CNT_W       = 6,
  parameter int unsigned BASE_PERIOD = 80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [2:0]       fs_code_i,
  input  logic             blocking_i,
  input  logic             adv_i,
  input  logic             ts_ok_i,
  output logic [CNT_W-1:0] blk_cnt_o,
  output logic             cnt_vld_o
);
  localparam int unsigned PH_W = $clog2(BASE_PERIOD + 1);
  localparam int unsigned HALF = BASE_PERIOD / 2;

  logic            run;
  pace_cfg_t       cfg;
  logic [PH_W-1:0] phase;
  logic [CNT_W-1:0] cnt_next;
  logic            take;

  assign take = adv_i && run && !start_i;

  pacer_cfg u_cfg (
    .clk(clk), .rst(rst), .start_i(start_i), .code_i(fs_code_i),
    .blocking_i(blocking_i), .run_o(run), .cfg_o(cfg)
  );

  pacer_phase #(.PH_W(PH_W), .BASE_PERIOD(BASE_PERIOD)) u_phase (
    .clk(clk), .rst(rst), .restart_i(start_i), .step_i(take),
    .cfg_i(cfg), .phase_o(phase)
  );

  pacer_count #(.PH_W(PH_W), .CNT_W(CNT_W), .HALF(HALF)) u_count (
    .cfg_i(cfg), .phase_i(phase), .ts_ok_i(ts_ok_i), .cnt_o(cnt_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_cnt_o <= '0;
      cnt_vld_o <= 1'b0;
    end else begin
      cnt_vld_o <= take;
      if (take) blk_cnt_o <= cnt_next;
    end
  end

  // R3
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_i && run && !start_i) |=> cnt_vld_o);
  // R3
  vld_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv_i || start_i) |=> !cnt_vld_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> !cnt_vld_o);
  // R5
  noinfo_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_i && run && !start_i && cfg.blocking && !ts_ok_i) |=> (blk_cnt_o == '0));
  // R11
  bad_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_i && run && !start_i && cfg.code == FS_BAD) |=> (blk_cnt_o == '0));
  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_vld_o |-> (blk_cnt_o <= CNT_W'(32)));
endmodule

// File: tb/sim_cycle_block_pacer.sv
`timescale 1ns/1ps
module sim_cycle_block_pacer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [2:0] fs_code_i = 3'd0;
  logic       blocking_i = 1'b0;
  logic       adv_i = 1'b0;
  logic       ts_ok_i = 1'b0;
  logic [5:0] blk_cnt_o;
  logic       cnt_vld_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  cycle_block_pacer u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .fs_code_i(fs_code_i),
    .blocking_i(blocking_i), .adv_i(adv_i), .ts_ok_i(ts_ok_i),
    .blk_cnt_o(blk_cnt_o), .cnt_vld_o(cnt_vld_o)
  );

  task automatic report_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      report_end();
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic start(input int code, input bit blk);
    @(negedge clk);
    start_i = 1'b1; fs_code_i = 3'(code); blocking_i = blk;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // one advance; result sampled at the negedge after the capturing edge
  task automatic step(input bit ts, output int cnt, output bit vld);
    @(negedge clk);
    adv_i = 1'b1; ts_ok_i = ts;
    @(negedge clk);
    adv_i = 1'b0; ts_ok_i = 1'b0;
    cnt = int'(blk_cnt_o); vld = cnt_vld_o;
  endtask

  function automatic int ref44(int p);
    return 5 + ((p % 2) ^ int'((p == 0) || (p >= 40)));
  endfunction

  task automatic t_reset();
    int c; bit v;
    chk("R1 count after reset", int'(blk_cnt_o), 0);
    chk("R1 vld after reset", int'(cnt_vld_o), 0);
    step(1'b1, c, v);
    chk("R1 no vld before start", int'(v), 0);
  endtask

  task automatic t_blocking();
    int c; bit v;
    int iv[7] = '{8, 8, 8, 16, 16, 32, 32};
    for (int k = 0; k < 7; k++) begin
      start(k, 1'b1);
      step(1'b1, c, v);
      chk("R4 blocking interval", c, iv[k]);
      chk("R3 vld pulse", int'(v), 1);
      step(1'b0, c, v);
      chk("R5 no-info gives zero", c, 0);
      @(negedge clk);
      chk("R3 vld single cycle", int'(cnt_vld_o), 0);
    end
  endtask

  task automatic t_even_rates();
    int c; bit v;
    int codes[4] = '{0, 2, 4, 6};
    int exp[4]   = '{4, 6, 12, 24};
    for (int k = 0; k < 4; k++) begin
      start(codes[k], 1'b0);
      step(1'b0, c, v);
      chk("R6 constant count ts=0", c, exp[k]);
      step(1'b1, c, v);
      chk("R6 constant count ts=1", c, exp[k]);
    end
  endtask

  task automatic t_phased(input int code, input int period);
    int c; bit v; int sum = 0;
    start(code, 1'b0);
    for (int p = 0; p < period; p++) begin
      step(1'b1, c, v);
      sum += c;
      if (code == 1) chk("R7 44.1k pattern", c, ref44(p));
      else if (code == 3) chk("R8 88.2k count", c, (p == 0) ? 12 : 11);
      else chk("R8 176.4k count", c, (p == 0) ? 23 : 22);
    end
    chk("R9 period total", sum, 441);
    step(1'b1, c, v);
    chk("R9 wrap to phase 0", c, (code == 1) ? 6 : (code == 3) ? 12 : 23);
  endtask

  task automatic t_restart();
    int c; bit v;
    start(1, 1'b0);
    step(1'b1, c, v); step(1'b1, c, v); step(1'b1, c, v);
    chk("R7 third count", c, 5);
    start(1, 1'b0);
    step(1'b1, c, v);
    chk("R10 restart phase 0", c, 6);
    step(1'b1, c, v);
    chk("R10 restart phase 1", c, 6);
  endtask

  task automatic t_hold();
    int c; bit v;
    start(2, 1'b0);
    @(negedge clk);
    fs_code_i = 3'd6; blocking_i = 1'b1;
    step(1'b0, c, v);
    chk("R2 config held", c, 6);
  endtask

  task automatic t_collide();
    int c; bit v;
    start(0, 1'b0);
    @(negedge clk);
    start_i = 1'b1; adv_i = 1'b1; fs_code_i = 3'd4; blocking_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0; adv_i = 1'b0;
    chk("R3 adv with start dropped", int'(cnt_vld_o), 0);
    step(1'b1, c, v);
    chk("R3 new config after collide", c, 12);
  endtask

  task automatic t_bad_code();
    int c; bit v;
    start(7, 1'b0);
    step(1'b1, c, v);
    chk("R11 code 7 non-blocking", c, 0);
    start(7, 1'b1);
    step(1'b1, c, v);
    chk("R11 code 7 blocking", c, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_blocking();
    t_even_rates();
    t_phased(1, 80);
    t_phased(3, 40);
    t_phased(5, 20);
    t_restart();
    t_hold();
    t_collide();
    t_bad_code();
    report_end();
  end
endmodule